// File: doc/BRIEF.md
# Fractional-N Division Controller

This block divides a fast oscillator clock by a ratio that is a whole number plus a binary fraction. A down-counter produces one output pulse every N oscillator cycles. At every output pulse, a fixed-width phase accumulator adds a fraction word. When that addition wraps past 2^W, the period that follows is stretched to N+1 cycles. Over many periods the average ratio is therefore N + frac/2^W.

A frequency synthesizer uses the output pulse as the feedback edge for its phase comparator. The overflow bit and the accumulator residue are also brought out, for the surrounding loop or for observation. The modulus and the fraction word may be changed at any time. The block takes them only at an output pulse, so the period in progress is never disturbed. An enable input freezes the whole block.

Top module: `fracn_div_ctrl`

## Requirements
- R1: While reset is asserted, div_pulse, ovf and residue are all 0. The counter starts with a period of RST_MOD cycles (1023 by default). The first pulse is therefore high at the 1022nd falling edge after reset is released, counting edges with en high.
- R2: div_pulse is high for exactly one clock per period. With no carry, the interval between pulses is N clock cycles.
- R3: At each pulse, frac is added to the residue modulo 2^W (W = 10). residue then shows the wrapped sum, and ovf shows the carry out of bit W-1. Both hold until the next pulse.
- R4: When a pulse produces a carry, the period that follows is N+1 cycles. The period after that returns to N unless another carry occurs.
- R5: Starting from a zero residue with frac = 100, pulses 1 to 10 produce no carry. Pulse 11 carries and leaves residue 76.
- R6: The carry rate is frac/2^W. frac = 512 carries on every other pulse. frac = 256 carries 16 times in any 64 consecutive pulses.
- R7: mod_n and frac are sampled only at a pulse. A change made mid-period affects neither the current period length nor residue before the next pulse.
- R8: While en is low, no pulse is produced, and the counter, residue and ovf hold their values. Counting resumes where it stopped.
- R9: An mod_n value of 0 or 1 is treated as 2.
- R10: With frac = 0, ovf stays 0 and every period is N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Count enable; low freezes all state |
| mod_n | input | MOD_W (11) | Nominal modulus N |
| frac | input | ACC_W (10) | Fraction word added per output period |
| div_pulse | output | 1 | One-clock divided output pulse |
| ovf | output | 1 | Carry of the latest accumulation |
| residue | output | ACC_W (10) | Accumulator content below capacity |

## Verification
The hardest case to reach from the ports is the exact pulse at which the accumulator wraps. This case must also coincide with an input change or a freeze, because only then is the sampling rule distinguishable from continuous sampling. The bench keeps a running model of the residue and aims each such event at it. It walks a fraction of 100 from a cleared accumulator to its eleventh addition. It changes the modulus and the fraction two cycles into a period. It drops the enable one cycle after a reload, and checks the length of every period against the carry predicted one pulse earlier.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
    localparam int ACC_W_DEF   = 10;
    localparam int MOD_W_DEF   = 11;
    localparam int RST_MOD_DEF = 1023;
    localparam int MIN_MOD     = 2;

    typedef enum logic {
        SEL_N  = 1'b0,
        SEL_N1 = 1'b1
    } modsel_e;
endpackage

// File: rtl/fracn_acc.sv
module fracn_acc #(
    parameter int ACC_W = fracn_pkg::ACC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [ACC_W-1:0] frac,
    output logic             carry_nxt_o,
    output logic             carry_o,
    output logic [ACC_W-1:0] resid_o
);
    typedef struct packed {
        logic [ACC_W-1:0] resid;
        logic             carry;
    } acc_st_t;

    acc_st_t          st_d, st_q;
    logic [ACC_W:0]   sum;

    always_comb begin
        sum  = {1'b0, st_q.resid} + {1'b0, frac};
        st_d = st_q;
        if (step) begin
            st_d.resid = sum[ACC_W-1:0];
            st_d.carry = sum[ACC_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign carry_nxt_o = sum[ACC_W];
    assign carry_o     = st_q.carry;
    assign resid_o     = st_q.resid;

    // R7
    resid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(resid_o) && $stable(carry_o)));
    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && carry_nxt_o) |=> (carry_o && resid_o < $past(resid_o)));
endmodule

// File: rtl/fracn_load.sv
module fracn_load #(
    parameter int MOD_W = fracn_pkg::MOD_W_DEF
) (
    input  logic [MOD_W-1:0] mod_n,
    input  logic             carry,
    output logic [MOD_W-1:0] load_o
);
    import fracn_pkg::*;
    localparam logic [MOD_W-1:0] MIN_N = MOD_W'(MIN_MOD);

    logic [MOD_W-1:0] n_eff;
    modsel_e          sel;

    always_comb begin
        n_eff  = (mod_n < MIN_N) ? MIN_N : mod_n;
        sel    = carry ? SEL_N1 : SEL_N;
        load_o = (sel == SEL_N1) ? n_eff : n_eff - MOD_W'(1);
    end

    // R9
    always_comb begin
        load_min_chk: assert (load_o >= MOD_W'(1));
    end
endmodule

// File: rtl/fracn_cnt.sv
module fracn_cnt #(
    parameter int MOD_W   = fracn_pkg::MOD_W_DEF,
    parameter int RST_MOD = fracn_pkg::RST_MOD_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [MOD_W-1:0] load_val,
    output logic             tick_o
);
    localparam logic [MOD_W-1:0] RST_LOAD = MOD_W'(RST_MOD - 1);

    typedef struct packed {
        logic [MOD_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    at_zero;

    always_comb begin
        at_zero = (st_q.cnt == '0);
        st_d    = st_q;
        if (en) begin
            if (at_zero) st_d.cnt = load_val;
            else         st_d.cnt = st_q.cnt - MOD_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.cnt <= RST_LOAD;
        else        st_q     <= st_d;
    end

    assign tick_o = en && at_zero;

    // R4
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (st_q.cnt == $past(load_val)));
    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(st_q.cnt));
    // R2
    down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick_o) |=> (st_q.cnt == $past(st_q.cnt) - MOD_W'(1)));
endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl #(
    parameter int ACC_W   = fracn_pkg::ACC_W_DEF,
    parameter int MOD_W   = fracn_pkg::MOD_W_DEF,
    parameter int RST_MOD = fracn_pkg::RST_MOD_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [MOD_W-1:0] mod_n,
    input  logic [ACC_W-1:0] frac,
    output logic             div_pulse,
    output logic             ovf,
    output logic [ACC_W-1:0] residue
);
    logic             tick;
    logic             carry_nxt;
    logic [MOD_W-1:0] load_val;

    fracn_acc #(.ACC_W(ACC_W)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (tick),
        .frac        (frac),
        .carry_nxt_o (carry_nxt),
        .carry_o     (ovf),
        .resid_o     (residue)
    );

    fracn_load #(.MOD_W(MOD_W)) u_load (
        .mod_n  (mod_n),
        .carry  (carry_nxt),
        .load_o (load_val)
    );

    fracn_cnt #(.MOD_W(MOD_W), .RST_MOD(RST_MOD)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .load_val (load_val),
        .tick_o   (tick)
    );

    assign div_pulse = tick;

    // R2
    pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);
    // R8
    no_pulse_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !div_pulse);
endmodule

// File: tb/sim_fracn_div_ctrl.sv
module sim_fracn_div_ctrl;
    localparam int W = 10;
    localparam int M = 11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [M-1:0] mod_n = '0;
    logic [W-1:0] frac = '0;
    logic         div_pulse, ovf;
    logic [W-1:0] residue;

    int n_chk = 0, n_fail = 0;
    int m_acc = 0, m_ovf = 0, m_period = 1023;

    always #2 clk = ~clk;

    fracn_div_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .mod_n(mod_n), .frac(frac),
        .div_pulse(div_pulse), .ovf(ovf), .residue(residue)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Waits for the next pulse; caller sits one negedge after the previous pulse.
    task automatic pulse(input int adj, input string req);
        int cyc = 0;
        int sum, neff;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (div_pulse || cyc > 4000) break;
        end
        check(cyc == m_period - 1 - adj, {req, " period"}, cyc, m_period - 1 - adj);
        sum      = m_acc + int'(frac);
        m_ovf    = sum >> W;
        m_acc    = sum % (1 << W);
        neff     = (mod_n < 2) ? 2 : int'(mod_n);
        m_period = neff + m_ovf;
        @(negedge clk);
        check(div_pulse == 1'b0, "R2 single-cycle pulse", int'(div_pulse), 0);
        check(int'(ovf) == m_ovf, {req, " ovf"}, int'(ovf), m_ovf);
        check(int'(residue) == m_acc, {req, " residue"}, int'(residue), m_acc);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; en = 1'b1; mod_n = 11'd5; frac = 10'd100;
        repeat (3) @(negedge clk);
        check(div_pulse == 1'b0, "R1 reset pulse", int'(div_pulse), 0);
        check(ovf == 1'b0, "R1 reset ovf", int'(ovf), 0);
        check(residue == '0, "R1 reset residue", int'(residue), 0);
        rst_n = 1'b1;
        m_acc = 0; m_ovf = 0; m_period = 1023;
    endtask

    task automatic t_frac100;
        for (int k = 1; k <= 12; k++) begin
            pulse(0, (k == 1) ? "R1 first" : ((k == 12) ? "R4 stretched" : "R5"));
            check(int'(ovf) == ((k == 11) ? 1 : 0), "R5 carry position", int'(ovf), (k == 11) ? 1 : 0);
            if (k == 11) check(residue == 10'd76, "R5 residue after wrap", int'(residue), 76);
        end
        pulse(0, "R4 back to N");
    endtask

    task automatic t_half;
        int nc = 0;
        mod_n = 11'd3; frac = 10'd512;
        pulse(0, "R6 half");
        for (int k = 0; k < 8; k++) begin
            pulse(0, "R6 half");
            nc += int'(ovf);
        end
        check(nc == 4, "R6 half carry count", nc, 4);
    endtask

    task automatic t_quarter;
        int nc = 0;
        mod_n = 11'd4; frac = 10'd256;
        pulse(0, "R6 quarter");
        for (int k = 0; k < 64; k++) begin
            pulse(0, "R6 quarter");
            nc += int'(ovf);
        end
        check(nc == 16, "R6 quarter carry count", nc, 16);
    endtask

    task automatic t_zero;
        frac = 10'd0; mod_n = 11'd4;
        pulse(0, "R10");
        for (int k = 0; k < 5; k++) begin
            pulse(0, "R10 no carry");
            check(ovf == 1'b0, "R10 ovf", int'(ovf), 0);
        end
    endtask

    task automatic t_midchange;
        mod_n = 11'd6; frac = 10'd40;
        pulse(0, "R7 setup");
        @(negedge clk); @(negedge clk);
        mod_n = 11'd9; frac = 10'd300;
        @(negedge clk);
        check(int'(residue) == m_acc, "R7 residue unchanged", int'(residue), m_acc);
        pulse(3, "R7 old period kept");
        pulse(0, "R7 new modulus");
    endtask

    task automatic t_freeze;
        mod_n = 11'd7; frac = 10'd600;
        pulse(0, "R8 setup");
        en = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check(div_pulse == 1'b0, "R8 no pulse frozen", int'(div_pulse), 0);
            check(int'(residue) == m_acc, "R8 residue frozen", int'(residue), m_acc);
        end
        en = 1'b1;
        pulse(0, "R8 resume");
    endtask

    task automatic t_clamp;
        frac = 10'd0; mod_n = 11'd1;
        pulse(0, "R9 setup");
        pulse(0, "R9 modulus 1");
        mod_n = 11'd0;
        pulse(0, "R9 modulus 1 applied");
        pulse(0, "R9 modulus 0");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog all-requirements actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        t_reset;
        t_frac100;
        t_half;
        t_quarter;
        t_zero;
        t_midchange;
        t_freeze;
        t_clamp;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule